// File: doc/BRIEF.md
# MSI Vector Receive and Interrupt Aggregator

This block takes message-signalled interrupt trigger writes and sorts them into eight event interrupt lines that lead to processor cores. A trigger write carries a vector number from 0 to 31. It does not carry a bitmask. The 32 vectors are interleaved across the events: event k owns vectors k, k+8, k+16 and k+24. Each event keeps one pending status bit for each of its vectors. Software sees those bits through a status register, and writing 1 to a bit clears it. A per-event enable selects which pending bits may interrupt. Enable bits are set through one register and cleared through another.

Each event line gives a one-cycle pulse. After it fires, the event is disarmed until software writes the end-of-interrupt register with the code for that event. The handler first clears the status bits it has serviced and then writes the end-of-interrupt code. If an enabled bit is still pending when the end-of-interrupt code arrives, the line pulses again at once, so a vector that arrived during servicing is not lost.

All register traffic uses a single request channel with valid/ready. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low while reset is asserted and high from the first edge after reset is released, so back-pressure appears only around reset. A sender must hold its request stable while `req_ready` is low. Every accepted read returns its data on `rsp_valid`/`rsp_rdata` exactly one cycle later. The response has no back-pressure.

Top module: `msi_vec_aggr`

## Requirements
- R1: The address is 5 bits. Bits [4:3] select a group: 0 = control, 1 = status, 2 = enable-set, 3 = enable-clear. Bits [2:0] select the event. In the control group, index 0 is the trigger register and index 1 is the end-of-interrupt register. An accepted write of value N (0 to 31) to the trigger register sets bit N/8 of the status of event N%8.
- R2: A trigger write with a value of 32 or more changes no status bit and produces no pulse.
- R3: Status bits accumulate. Vectors 8 and then 0 leave event 0's status reading 0x3.
- R4: A write to an event's status register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: A write to enable-set ORs the low four data bits into the event's enable. A write to enable-clear removes the bits written as 1. A read of either address returns the enable, and a read of a control address returns 0.
- R6: An event line pulses for exactly one cycle. It pulses only when the event is armed and has a pending bit whose enable is set. The pulse is high during the cycle after the cycle in which that condition first holds. A pending bit that is not enabled raises no pulse until it is enabled.
- R7: After a pulse the event stays disarmed. New vectors arriving while it is disarmed raise no further pulse.
- R8: An end-of-interrupt write of value 4+k (k from 0 to 7) re-arms event k only. If an enabled bit is still pending, the event pulses again. Values outside 4 to 11 re-arm nothing.
- R9: `req_ready` is low during reset. Every accepted read gives `rsp_valid` high for one cycle, in the cycle right after the read is accepted. Writes give no response.
- R10: After reset every status and enable is 0, every event is armed, and every event line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Group in [4:3], event or control index in [2:0] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data, status or enable in the low four bits |
| evt_irq | output | 8 | One pulse line per event |

## Verification
A wrong status or enable bit shows up on the next read of that event, one cycle after the read is accepted. If the bit is enabled, it also shows up as a pulse that is missing or extra on the event line one cycle after the fault. A stuck or wrongly cleared arm flag shows up as a lost or repeated pulse within a cycle of the next enabled vector or end-of-interrupt write. Pulses are counted per line, so both duplicates and pulses on the wrong line can be seen. A mistake in mapping vectors to events or bits puts a set bit into a different event's status readback, and that readback follows the trigger directly.

// File: rtl/msi_aggr_pkg.sv
package msi_aggr_pkg;

  // Register group selected by the upper two address bits.
  typedef enum logic [1:0] {
    GRP_CTRL  = 2'd0,
    GRP_STAT  = 2'd1,
    GRP_ENSET = 2'd2,
    GRP_ENCLR = 2'd3
  } reg_grp_e;

  // Indices inside the control group.
  localparam int CTRL_TRIG_IDX = 0;
  localparam int CTRL_EOI_IDX  = 1;

endpackage

// File: rtl/msi_req_decode.sv
module msi_req_decode
  import msi_aggr_pkg::*;
#(
  parameter int NUM_EVENTS    = 8,
  parameter int VEC_PER_EVENT = 4,
  parameter int DATA_W        = 32,
  parameter int EOI_BASE      = 4
) (
  input  logic                                     wr_fire,
  input  logic [$clog2(NUM_EVENTS)+1:0]            addr,
  input  logic [DATA_W-1:0]                        wdata,
  output logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] set_mask,
  output logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] clr_mask,
  output logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] ens_mask,
  output logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] enc_mask,
  output logic [NUM_EVENTS-1:0]                    eoi_hit
);

  localparam int EV_W        = $clog2(NUM_EVENTS);
  localparam int VB_W        = $clog2(VEC_PER_EVENT);
  localparam int NUM_VECTORS = NUM_EVENTS * VEC_PER_EVENT;

  reg_grp_e          grp;
  logic [EV_W-1:0]   idx;
  logic              trig_ok;
  logic              eoi_ok;
  logic [EV_W-1:0]   trig_ev;
  logic [VB_W-1:0]   trig_bit;
  logic [DATA_W-1:0] eoi_rel;
  logic [EV_W-1:0]   eoi_ev;

  always_comb begin
    grp      = reg_grp_e'(addr[EV_W+1:EV_W]);
    idx      = addr[EV_W-1:0];
    // vector number N: event = N mod NUM_EVENTS, bit = N / NUM_EVENTS
    trig_ev  = wdata[EV_W-1:0];
    trig_bit = wdata[EV_W+VB_W-1:EV_W];
    trig_ok  = wr_fire && (grp == GRP_CTRL) && (idx == EV_W'(CTRL_TRIG_IDX))
               && (wdata < DATA_W'(NUM_VECTORS));
    eoi_rel  = wdata - DATA_W'(EOI_BASE);
    eoi_ev   = eoi_rel[EV_W-1:0];
    eoi_ok   = wr_fire && (grp == GRP_CTRL) && (idx == EV_W'(CTRL_EOI_IDX))
               && (wdata >= DATA_W'(EOI_BASE))
               && (wdata < DATA_W'(EOI_BASE + NUM_EVENTS));
  end

  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_ev
    logic hit_ev;
    assign hit_ev      = (idx == EV_W'(k));
    assign set_mask[k] = (trig_ok && (trig_ev == EV_W'(k)))
                         ? (VEC_PER_EVENT'(1) << trig_bit) : '0;
    assign clr_mask[k] = (wr_fire && grp == GRP_STAT  && hit_ev) ? wdata[VEC_PER_EVENT-1:0] : '0;
    assign ens_mask[k] = (wr_fire && grp == GRP_ENSET && hit_ev) ? wdata[VEC_PER_EVENT-1:0] : '0;
    assign enc_mask[k] = (wr_fire && grp == GRP_ENCLR && hit_ev) ? wdata[VEC_PER_EVENT-1:0] : '0;
    assign eoi_hit[k]  = eoi_ok && (eoi_ev == EV_W'(k));
  end

endmodule

// File: rtl/msi_event_slice.sv
module msi_event_slice #(
  parameter int VEC_PER_EVENT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VEC_PER_EVENT-1:0] set_mask,
  input  logic [VEC_PER_EVENT-1:0] clr_mask,
  input  logic [VEC_PER_EVENT-1:0] ens_mask,
  input  logic [VEC_PER_EVENT-1:0] enc_mask,
  input  logic                     eoi,
  output logic [VEC_PER_EVENT-1:0] status,
  output logic [VEC_PER_EVENT-1:0] enable,
  output logic                     irq
);

  logic armed;
  logic fire;

  // Pending bits gated by enable; fire once per arming.
  assign fire = armed && (|(status & enable));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      armed  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_mask) | set_mask;
      enable <= (enable | ens_mask) & ~enc_mask;
      irq    <= fire;
      if (fire)     armed <= 1'b0;
      else if (eoi) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/msi_rsp_port.sv
module msi_rsp_port
  import msi_aggr_pkg::*;
#(
  parameter int NUM_EVENTS    = 8,
  parameter int VEC_PER_EVENT = 4,
  parameter int DATA_W        = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     rd_fire,
  input  logic [$clog2(NUM_EVENTS)+1:0]            addr,
  input  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] stat_arr,
  input  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] en_arr,
  output logic                                     rsp_valid,
  output logic [DATA_W-1:0]                        rsp_rdata
);

  localparam int EV_W = $clog2(NUM_EVENTS);

  reg_grp_e                 grp;
  logic [EV_W-1:0]          idx;
  logic [VEC_PER_EVENT-1:0] sel;

  always_comb begin
    grp = reg_grp_e'(addr[EV_W+1:EV_W]);
    idx = addr[EV_W-1:0];
    unique case (grp)
      GRP_STAT:            sel = stat_arr[idx];
      GRP_ENSET, GRP_ENCLR: sel = en_arr[idx];
      default:             sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= DATA_W'(sel);
    end
  end

endmodule

// File: rtl/msi_vec_aggr.sv
module msi_vec_aggr #(
  parameter int NUM_EVENTS    = 8,
  parameter int VEC_PER_EVENT = 4,
  parameter int DATA_W        = 32,
  parameter int EOI_BASE      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [$clog2(NUM_EVENTS)+1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic [NUM_EVENTS-1:0]         evt_irq
);

  logic wr_fire;
  logic rd_fire;

  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] set_mask;
  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] clr_mask;
  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] ens_mask;
  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] enc_mask;
  logic [NUM_EVENTS-1:0]                    eoi_hit;
  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] stat_arr;
  logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] en_arr;

  // Ready only once out of reset; single request per cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= 1'b1;
  end

  assign wr_fire = req_valid && req_ready && req_write;
  assign rd_fire = req_valid && req_ready && !req_write;

  msi_req_decode #(
    .NUM_EVENTS   (NUM_EVENTS),
    .VEC_PER_EVENT(VEC_PER_EVENT),
    .DATA_W       (DATA_W),
    .EOI_BASE     (EOI_BASE)
  ) u_dec (
    .wr_fire (wr_fire),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .ens_mask(ens_mask),
    .enc_mask(enc_mask),
    .eoi_hit (eoi_hit)
  );

  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_slice
    msi_event_slice #(
      .VEC_PER_EVENT(VEC_PER_EVENT)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(set_mask[k]),
      .clr_mask(clr_mask[k]),
      .ens_mask(ens_mask[k]),
      .enc_mask(enc_mask[k]),
      .eoi     (eoi_hit[k]),
      .status  (stat_arr[k]),
      .enable  (en_arr[k]),
      .irq     (evt_irq[k])
    );
  end

  msi_rsp_port #(
    .NUM_EVENTS   (NUM_EVENTS),
    .VEC_PER_EVENT(VEC_PER_EVENT),
    .DATA_W       (DATA_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .addr     (req_addr),
    .stat_arr (stat_arr),
    .en_arr   (en_arr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/msi_vec_aggr_chk.sv
module msi_vec_aggr_chk
  import msi_aggr_pkg::*;
#(
  parameter int NUM_EVENTS    = 8,
  parameter int VEC_PER_EVENT = 4,
  parameter int DATA_W        = 32
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     req_valid,
  input logic                                     req_ready,
  input logic                                     req_write,
  input logic [$clog2(NUM_EVENTS)+1:0]            req_addr,
  input logic [DATA_W-1:0]                        req_wdata,
  input logic                                     rsp_valid,
  input logic [NUM_EVENTS-1:0]                    evt_irq,
  input logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] stat_arr,
  input logic [NUM_EVENTS-1:0][VEC_PER_EVENT-1:0] en_arr
);

  localparam int EV_W        = $clog2(NUM_EVENTS);
  localparam int NUM_VECTORS = NUM_EVENTS * VEC_PER_EVENT;

  logic acc_wr;
  logic acc_rd;
  assign acc_wr = req_valid && req_ready && req_write;
  assign acc_rd = req_valid && req_ready && !req_write;

  // R9: a response follows every accepted read, and only such a read
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  a_r9_rsp_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_rd));

  // R2: out-of-range trigger leaves all status untouched
  a_r2_big_trigger_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == {GRP_CTRL, EV_W'(CTRL_TRIG_IDX)}
     && req_wdata >= DATA_W'(NUM_VECTORS)) |=> $stable(stat_arr));

  for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_ev
    // R6: pulses last one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq[k] |=> !evt_irq[k]);
    // R6: a pulse needs an enabled pending bit one cycle earlier
    a_r6_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq[k] |-> $past(|(stat_arr[k] & en_arr[k])));
    // R4: write-one-to-clear removes the written bits
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && req_addr == {GRP_STAT, EV_W'(k)})
      |=> ((stat_arr[k] & $past(req_wdata[VEC_PER_EVENT-1:0])) == '0));
  end

endmodule

bind msi_vec_aggr msi_vec_aggr_chk #(
  .NUM_EVENTS   (NUM_EVENTS),
  .VEC_PER_EVENT(VEC_PER_EVENT),
  .DATA_W       (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .evt_irq  (evt_irq),
  .stat_arr (stat_arr),
  .en_arr   (en_arr)
);

// File: tb/msi_vec_aggr_bench.sv
`timescale 1ns/1ps
module msi_vec_aggr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  evt_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int irq_cnt [8];

  always #10 clk = ~clk;

  msi_vec_aggr u_msi_vec_aggr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .evt_irq  (evt_irq)
  );

  initial for (int k = 0; k < 8; k++) irq_cnt[k] = 0;

  always @(negedge clk)
    if (rst_n)
      for (int k = 0; k < 8; k++) irq_cnt[k] <= irq_cnt[k] + int'(evt_irq[k]);

  localparam int G_CTRL = 0, G_STAT = 1, G_ENS = 2, G_ENC = 3;

  function automatic logic [4:0] ra(int grp, int k);
    return 5'(grp * 8 + k);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; d = rsp_rdata;
  endtask

  task automatic expect_reg(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    check({req, " rsp_valid"}, 32'(v), 32'd1);
    check(req, d, exp);
  endtask

  // Let pulses land in the counters, then read them mid-cycle.
  task automatic settle_cnt(output int c [8]);
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    for (int k = 0; k < 8; k++) c[k] = irq_cnt[k];
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R9 ready low in reset", 32'(req_ready), 32'd0);
    check("R10 irq low in reset", 32'(evt_irq), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      expect_reg("R10 status zero", ra(G_STAT, k), 32'd0);
      expect_reg("R10 enable zero", ra(G_ENS, k), 32'd0);
    end
    expect_reg("R5 control read zero", ra(G_CTRL, 0), 32'd0);
  endtask

  task automatic test_decode();
    int vecs [5] = '{0, 8, 31, 13, 22};
    int c0 [8]; int c1 [8];
    settle_cnt(c0);
    foreach (vecs[i]) begin
      wr(ra(G_CTRL, 0), 32'(vecs[i]));
      expect_reg("R1 vector decode", ra(G_STAT, vecs[i] % 8), 32'(1 << (vecs[i] / 8)));
      wr(ra(G_STAT, vecs[i] % 8), 32'hF);
      expect_reg("R4 cleared", ra(G_STAT, vecs[i] % 8), 32'd0);
    end
    settle_cnt(c1);
    for (int k = 0; k < 8; k++) check("R6 no pulse without enable", 32'(c1[k] - c0[k]), 32'd0);
  endtask

  task automatic test_ignore();
    logic [31:0] bad [3] = '{32'd32, 32'd100, 32'hFFFF_FFFF};
    foreach (bad[i]) wr(ra(G_CTRL, 0), bad[i]);
    for (int k = 0; k < 8; k++) expect_reg("R2 oversize trigger ignored", ra(G_STAT, k), 32'd0);
  endtask

  task automatic test_accumulate();
    wr(ra(G_CTRL, 0), 32'd8);
    wr(ra(G_CTRL, 0), 32'd0);
    expect_reg("R3 accumulate", ra(G_STAT, 0), 32'h3);
    wr(ra(G_STAT, 0), 32'h2);
    expect_reg("R4 partial clear", ra(G_STAT, 0), 32'h1);
    wr(ra(G_STAT, 0), 32'h1);
    expect_reg("R4 final clear", ra(G_STAT, 0), 32'h0);
  endtask

  task automatic test_enable();
    wr(ra(G_ENS, 3), 32'h5);
    expect_reg("R5 enable set", ra(G_ENS, 3), 32'h5);
    wr(ra(G_ENS, 3), 32'h2);
    expect_reg("R5 enable OR", ra(G_ENS, 3), 32'h7);
    wr(ra(G_ENC, 3), 32'h4);
    expect_reg("R5 enable clear", ra(G_ENC, 3), 32'h3);
    wr(ra(G_ENC, 3), 32'hF);
    expect_reg("R5 enable all clear", ra(G_ENS, 3), 32'h0);
  endtask

  task automatic test_pulse_and_eoi();
    int c0 [8]; int c1 [8];
    wr(ra(G_ENS, 2), 32'hF);
    settle_cnt(c0);
    wr(ra(G_CTRL, 0), 32'd2);
    check("R9 no response to write", 32'(rsp_valid), 32'd0);
    check("R6 pulse not yet", 32'(evt_irq[2]), 32'd0);
    @(negedge clk);
    check("R6 pulse high", 32'(evt_irq), 32'h04);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(evt_irq[2]), 32'd0);
    wr(ra(G_CTRL, 0), 32'd10);
    settle_cnt(c1);
    check("R7 no pulse while disarmed", 32'(c1[2] - c0[2]), 32'd1);
    expect_reg("R3 bits pending", ra(G_STAT, 2), 32'h3);
    wr(ra(G_STAT, 2), 32'h3);
    wr(ra(G_CTRL, 1), 32'd6);
    settle_cnt(c0);
    check("R8 eoi with nothing pending", 32'(c0[2] - c1[2]), 32'd0);
    wr(ra(G_CTRL, 0), 32'd18);
    settle_cnt(c1);
    check("R8 rearmed pulse", 32'(c1[2] - c0[2]), 32'd1);
    wr(ra(G_CTRL, 1), 32'd5);
    wr(ra(G_CTRL, 1), 32'd3);
    wr(ra(G_CTRL, 1), 32'd12);
    settle_cnt(c0);
    for (int k = 0; k < 8; k++) check("R8 wrong eoi ignored", 32'(c0[k] - c1[k]), 32'd0);
    wr(ra(G_CTRL, 1), 32'd6);
    check("R8 eoi pulse not yet", 32'(evt_irq[2]), 32'd0);
    @(negedge clk);
    check("R8 eoi repulse", 32'(evt_irq), 32'h04);
    wr(ra(G_STAT, 2), 32'hF);
    wr(ra(G_CTRL, 1), 32'd6);
    wr(ra(G_ENC, 2), 32'hF);
  endtask

  task automatic test_mask();
    int c0 [8]; int c1 [8];
    wr(ra(G_ENS, 5), 32'h1);
    settle_cnt(c0);
    wr(ra(G_CTRL, 0), 32'd13);
    settle_cnt(c1);
    check("R6 masked bit no pulse", 32'(c1[5] - c0[5]), 32'd0);
    wr(ra(G_ENS, 5), 32'h2);
    settle_cnt(c0);
    check("R6 enable pending pulses", 32'(c0[5] - c1[5]), 32'd1);
    for (int k = 0; k < 8; k++)
      if (k != 5) check("R6 other lines quiet", 32'(c0[k] - c1[k]), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    test_decode();
    test_ignore();
    test_accumulate();
    test_enable();
    test_pulse_and_eoi();
    test_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule